// File: doc/BRIEF.md
# ADC Result Buffer Sequencer

This block sequences an external analog-to-digital converter and files its 10-bit samples into eight result registers, A through H. A sequence begins on a software start, a timer strobe or an external strobe. The sequencer then walks a list of channels that depends on a 2-bit buffer field and a 3-bit channel field. It asks the converter for one sample at a time over a request/done handshake.

In buffered modes, the channel 0 result (and the channel 1 result in pair mode) does not overwrite a fixed register. Before it lands in A, the older results are pushed down a short chain. Software therefore finds a short history of the same input. Group channels 4 to 7 can run alongside the buffered input and write straight to E through H. An end-of-sequence flag is raised after a mode-dependent number of passes. The flag can drive an interrupt. Software clears it by reading the control word and then writing a zero. Single mode halts after the flag. Scan mode restarts the list until scan is switched off.

Top module: `adc_buf_seq`

## Requirements
- R1: After reset, the control word (address 0) reads 0, every result register reads 0, and `conv_req` and `irq` are low.
- R2: `irq` is high exactly when the flag (control bit 0) and the interrupt enable (control bit 1) are both 1.
- R3: The flag clears only when a write to address 0 carries 0 in bit 0 and follows a read of address 0 that returned the flag as 1. A write of 0 without such a read leaves the flag set.
- R4: A sequence starts from idle on a write of 1 to control bit 2, on a `tmr_trig` pulse while bit 9 is 1, or on an `ext_trig` pulse while bit 10 is 1. A strobe whose enable is 0 starts nothing. Any start while busy (bit 2 reads 1) is ignored and does not restart the count.
- R5: In single mode (bit 3 = 0), `conv_req` falls once the flag is set, and no conversion follows until the next start.
- R6: In scan mode (bit 3 = 1), conversion goes on after the flag is set, restarting the list. Clearing bit 3 stops the block at the end of the current sequence.
- R7: With buffer field (bits 5:4) 01, channel 0 is converted twice. Each result moves A to B and then enters A, while C and D hold. The flag sets after the second conversion.
- R8: With buffer field 11, channel 0 is converted four times. Each result moves C to D, B to C and A to B, and then enters A. The flag sets after the fourth conversion.
- R9: With buffer field 10, each pass converts channel 0 and then channel 1. Each of those results shifts the four-deep chain as in R8. The flag sets after the second pass.
- R10: In a buffered mode, channel bit 8 = 1 adds group channels 4 to 4+bits 7:6 after the buffered conversions of every pass. Channel 4+k writes register 4+k without shifting. With bit 8 = 0, no group channels are added.
- R11: With buffer field 00, one pass converts channels b to b+bits 7:6, where b is 4 if bit 8 is 1 and 0 otherwise. Each channel n writes register n. The flag sets after the pass.
- R12: The flag stays 0 until the final conversion of a sequence has completed. `conv_ch` carries the number of the channel being converted.
- R13: Result register n (A = 0 … H = 7) reads at address 8+n in bits 9:0. Reads have no side effect, and values change only when a conversion stores into them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address: 0 control, 8..15 results |
| bus_wdata | input | 11 | Write data for the control word |
| bus_rdata | output | 16 | Read data |
| tmr_trig | input | 1 | Timer start strobe |
| ext_trig | input | 1 | External start strobe |
| conv_req | output | 1 | Conversion request, held until done |
| conv_ch | output | 3 | Channel to convert |
| conv_done | input | 1 | One-cycle conversion complete |
| conv_data | input | 10 | Sample returned with done |
| irq | output | 1 | Conversion-end interrupt |

## Verification
The bench builds the block with its default 10-bit sample width and attaches a converter model with a three-cycle latency. That latency leaves room for a second start strobe, and for clearing the scan bit, while a pass is still running. Every sample carries its channel and a running serial number. Because of that, a wrong shift, a wrong target register or a missing or extra conversion changes a value the scoreboard compares. The chosen channel fields include group channels 4 to 6 next to a four-deep chain, so register H must stay untouched.

// File: rtl/adc_buf_pkg.sv
package adc_buf_pkg;

  localparam int unsigned CH_W     = 3;
  localparam int unsigned NREG     = 2 ** CH_W;
  localparam int unsigned CHAIN_D  = 4;
  localparam int unsigned CTL_W    = 11;
  localparam int unsigned ADDR_W   = CH_W + 1;

  typedef enum logic [1:0] {
    BUF_OFF  = 2'b00,
    BUF_TWO  = 2'b01,
    BUF_PAIR = 2'b10,
    BUF_FOUR = 2'b11
  } buf_mode_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_CONV = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic            shift;
    logic            deep;
    logic [CH_W-1:0] idx;
  } store_cmd_t;

endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_buf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            scan_i,
  input  buf_mode_e       mode_i,
  input  logic [CH_W-1:0] chan_i,
  input  logic            conv_done_i,
  output logic            conv_req_o,
  output logic [CH_W-1:0] conv_ch_o,
  output logic            busy_o,
  output logic            store_o,
  output store_cmd_t      cmd_o,
  output logic            set_flag_o
);

  seq_state_e      state_q, state_d;
  buf_mode_e       mode_q, mode_d;
  logic [CH_W-1:0] chan_q, chan_d;
  logic [2:0]      slot_q, slot_d;
  logic [1:0]      pass_q, pass_d;
  logic            seq_en;

  logic [2:0]      nbuf, ngrp, last_slot, grp_off;
  logic [CH_W-1:0] base_ch;
  logic [1:0]      last_pass;
  logic            is_buf, end_pass, end_seq;

  // pass shape from the latched configuration
  always_comb begin
    case (mode_q)
      BUF_OFF:  begin nbuf = 3'd0; last_pass = 2'd0; end
      BUF_TWO:  begin nbuf = 3'd1; last_pass = 2'd1; end
      BUF_PAIR: begin nbuf = 3'd2; last_pass = 2'd1; end
      default:  begin nbuf = 3'd1; last_pass = 2'd3; end
    endcase
    if ((mode_q == BUF_OFF) || chan_q[2])
      ngrp = {1'b0, chan_q[1:0]} + 3'd1;
    else
      ngrp = 3'd0;
    base_ch   = chan_q[2] ? CH_W'(4) : CH_W'(0);
    last_slot = nbuf + ngrp - 3'd1;
    is_buf    = (slot_q < nbuf);
    grp_off   = slot_q - nbuf;
    end_pass  = (slot_q == last_slot);
    end_seq   = end_pass && (pass_q == last_pass);
  end

  always_comb begin
    conv_ch_o   = is_buf ? slot_q : (base_ch + grp_off);
    cmd_o.shift = is_buf;
    cmd_o.deep  = (mode_q != BUF_TWO);
    cmd_o.idx   = conv_ch_o;
  end

  assign conv_req_o = (state_q == SQ_CONV);
  assign busy_o     = conv_req_o;
  assign store_o    = conv_req_o && conv_done_i;
  assign set_flag_o = store_o && end_seq;

  // next state
  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    chan_d  = chan_q;
    slot_d  = slot_q;
    pass_d  = pass_q;
    seq_en  = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (start_i) begin
          seq_en  = 1'b1;
          state_d = SQ_CONV;
          mode_d  = mode_i;
          chan_d  = chan_i;
          slot_d  = 3'd0;
          pass_d  = 2'd0;
        end
      end
      SQ_CONV: begin
        if (conv_done_i) begin
          seq_en = 1'b1;
          if (!end_pass) begin
            slot_d = slot_q + 3'd1;
          end else begin
            slot_d = 3'd0;
            if (!end_seq) begin
              pass_d = pass_q + 2'd1;
            end else begin
              pass_d = 2'd0;
              if (!scan_i) state_d = SQ_IDLE;
            end
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      mode_q  <= BUF_OFF;
      chan_q  <= '0;
      slot_q  <= '0;
      pass_q  <= '0;
    end else if (seq_en) begin
      state_q <= state_d;
      mode_q  <= mode_d;
      chan_q  <= chan_d;
      slot_q  <= slot_d;
      pass_q  <= pass_d;
    end
  end

  AST_BUSY_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_CONV && start_i && !conv_done_i) |=>
      (state_q == SQ_CONV && $stable(slot_q) && $stable(pass_q))); // R4

  AST_SINGLE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flag_o && !scan_i) |=> !conv_req_o); // R5

  AST_SCAN_KEEPS_GOING: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flag_o && scan_i) |=> conv_req_o); // R6

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_buf_pkg::*;
#(
  parameter int unsigned DW = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     store_i,
  input  store_cmd_t               cmd_i,
  input  logic [DW-1:0]            data_i,
  output logic [NREG-1:0][DW-1:0]  regs_o
);

  for (genvar i = 0; i < NREG; i++) begin : g_res
    logic          en;
    logic [DW-1:0] nxt;
    logic [DW-1:0] q;

    if (i == 0) begin : g_head
      always_comb begin
        en  = store_i && (cmd_i.shift || (cmd_i.idx == CH_W'(i)));
        nxt = data_i;
      end
    end else if (i < CHAIN_D) begin : g_chain
      always_comb begin
        if (cmd_i.shift) begin
          en  = store_i && (cmd_i.deep || (i == 1));
          nxt = regs_o[i-1];
        end else begin
          en  = store_i && (cmd_i.idx == CH_W'(i));
          nxt = data_i;
        end
      end
    end else begin : g_direct
      always_comb begin
        en  = store_i && !cmd_i.shift && (cmd_i.idx == CH_W'(i));
        nxt = data_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= nxt;
    end

    assign regs_o[i] = q;
  end

  AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !store_i |=> $stable(regs_o)); // R13

  AST_TWO_DEEP_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (store_i && cmd_i.shift && !cmd_i.deep) |=>
      (regs_o[1] == $past(regs_o[0]) && regs_o[0] == $past(data_i) &&
       $stable(regs_o[2]) && $stable(regs_o[3]))); // R7

  AST_FOUR_DEEP_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (store_i && cmd_i.shift && cmd_i.deep) |=>
      (regs_o[3] == $past(regs_o[2]) && regs_o[2] == $past(regs_o[1]) &&
       regs_o[1] == $past(regs_o[0]) && regs_o[0] == $past(data_i))); // R8

  AST_GROUP_SPARES_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (store_i && !cmd_i.shift && cmd_i.idx[CH_W-1]) |=>
      $stable(regs_o[CHAIN_D-1:0])); // R10

endmodule

// File: rtl/adc_flag_ctl.sv
module adc_flag_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic stat_rd_i,
  input  logic clr_wr_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o
);

  logic flag_q, flag_d;
  logic armed_q, armed_d;
  logic clr_ok;

  assign clr_ok = clr_wr_i && armed_q && flag_q;

  always_comb begin
    if (set_i)       flag_d = 1'b1;
    else if (clr_ok) flag_d = 1'b0;
    else             flag_d = flag_q;
    armed_d = flag_d && (armed_q || (stat_rd_i && flag_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && ie_i;

  AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(armed_q)); // R3

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q); // R12

endmodule

// File: rtl/adc_buf_seq.sv
module adc_buf_seq
  import adc_buf_pkg::*;
#(
  parameter int unsigned DW   = 10,
  parameter int unsigned RD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CTL_W-1:0]  bus_wdata,
  output logic [RD_W-1:0]   bus_rdata,
  input  logic              tmr_trig,
  input  logic              ext_trig,
  output logic              conv_req,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_done,
  input  logic [DW-1:0]     conv_data,
  output logic              irq
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_s2, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end
  assign rst_ns = rst_s2;

  // control word
  logic            ie_q, ie_d, scan_q, scan_d, ten_q, ten_d, een_q, een_d;
  buf_mode_e       mode_q, mode_d;
  logic [CH_W-1:0] chan_q, chan_d;
  logic            ctl_sel, ctl_wr, ctl_rd;
  logic            start, busy, store, set_flag, flag;
  store_cmd_t      cmd;
  logic [NREG-1:0][DW-1:0] regs;

  assign ctl_sel = (bus_addr == '0);
  assign ctl_wr  = bus_wr && ctl_sel;
  assign ctl_rd  = bus_rd && ctl_sel;

  always_comb begin
    ie_d   = ie_q;
    scan_d = scan_q;
    mode_d = mode_q;
    chan_d = chan_q;
    ten_d  = ten_q;
    een_d  = een_q;
    if (ctl_wr) begin
      ie_d   = bus_wdata[1];
      scan_d = bus_wdata[3];
      mode_d = buf_mode_e'(bus_wdata[5:4]);
      chan_d = bus_wdata[8:6];
      ten_d  = bus_wdata[9];
      een_d  = bus_wdata[10];
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ie_q   <= 1'b0;
      scan_q <= 1'b0;
      mode_q <= BUF_OFF;
      chan_q <= '0;
      ten_q  <= 1'b0;
      een_q  <= 1'b0;
    end else if (ctl_wr) begin
      ie_q   <= ie_d;
      scan_q <= scan_d;
      mode_q <= mode_d;
      chan_q <= chan_d;
      ten_q  <= ten_d;
      een_q  <= een_d;
    end
  end

  assign start = (ctl_wr && bus_wdata[2]) || (tmr_trig && ten_q) || (ext_trig && een_q);

  adc_seq_fsm i_seq (
    .clk         (clk),
    .rst_n       (rst_ns),
    .start_i     (start),
    .scan_i      (scan_q),
    .mode_i      (mode_d),
    .chan_i      (chan_d),
    .conv_done_i (conv_done),
    .conv_req_o  (conv_req),
    .conv_ch_o   (conv_ch),
    .busy_o      (busy),
    .store_o     (store),
    .cmd_o       (cmd),
    .set_flag_o  (set_flag)
  );

  adc_result_bank #(.DW(DW)) i_bank (
    .clk     (clk),
    .rst_n   (rst_ns),
    .store_i (store),
    .cmd_i   (cmd),
    .data_i  (conv_data),
    .regs_o  (regs)
  );

  adc_flag_ctl i_flag (
    .clk       (clk),
    .rst_n     (rst_ns),
    .set_i     (set_flag),
    .stat_rd_i (ctl_rd),
    .clr_wr_i  (ctl_wr && !bus_wdata[0]),
    .ie_i      (ie_q),
    .flag_o    (flag),
    .irq_o     (irq)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (ctl_sel)
      bus_rdata[CTL_W-1:0] = {een_q, ten_q, chan_q, mode_q, scan_q, busy, ie_q, flag};
    else if (bus_addr[ADDR_W-1])
      bus_rdata[DW-1:0] = regs[bus_addr[CH_W-1:0]];
  end

  AST_FLAG_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(flag) |-> $past(conv_done)); // R12

endmodule

// File: tb/test_adc_buf_seq.sv
module test_adc_buf_seq;

  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [10:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        tmr_trig = 1'b0, ext_trig = 1'b0;
  logic        conv_req;
  logic [2:0]  conv_ch;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_data = '0;
  logic        irq;

  always #10 clk = ~clk;

  adc_buf_seq i_adc_buf_seq (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_trig(tmr_trig), .ext_trig(ext_trig), .conv_req(conv_req),
    .conv_ch(conv_ch), .conv_done(conv_done), .conv_data(conv_data), .irq(irq)
  );

  typedef struct {
    int    ch;
    int    kind;   // 0 direct, 2 two-deep shift, 4 four-deep shift
    string tag;
  } exp_t;

  exp_t        q[$];
  logic [9:0]  model [8];
  int          checks = 0, fails = 0, popped = 0;
  int          seqn = 0;
  logic [10:0] cur = '0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(int ch, int kind, string tag);
    exp_t e;
    e.ch = ch; e.kind = kind; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor side of the scoreboard: pop, compare channel, update the model
  task automatic observe(int ch, logic [9:0] d);
    exp_t e;
    if (q.size() == 0) begin
      chk("R12", "unexpected conversion", ch, -1);
      return;
    end
    e = q.pop_front();
    popped++;
    chk(e.tag, "conversion channel", ch, e.ch);
    if (e.kind == 0) begin
      model[e.ch] = d;
    end else if (e.kind == 2) begin
      model[1] = model[0]; model[0] = d;
    end else begin
      model[3] = model[2]; model[2] = model[1]; model[1] = model[0]; model[0] = d;
    end
  endtask

  // converter model
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (conv_req) begin
        cnt++;
        if (cnt == LAT) begin
          conv_data = {conv_ch, seqn[6:0]};
          seqn++;
          conv_done = 1'b1;
          cnt = 0;
          observe(int'(conv_ch), conv_data);
        end else begin
          conv_done = 1'b0;
        end
      end else begin
        cnt = 0;
        conv_done = 1'b0;
      end
    end
  end

  task automatic wr(logic [3:0] a, logic [10:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_tmr();
    @(negedge clk); tmr_trig = 1'b1;
    @(negedge clk); tmr_trig = 1'b0;
  endtask

  task automatic pulse_ext();
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
  endtask

  function automatic logic [10:0] cfg(bit ie, bit st, bit sc, bit [1:0] md,
                                      bit [2:0] ch, bit te, bit ee);
    return {ee, te, ch, md, sc, st, ie, 1'b1};
  endfunction

  task automatic wait_idle();
    wait (q.size() == 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_regs(string req);
    logic [15:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(4'(8 + i), d);
      chk(req, $sformatf("result register %0d", i), int'(d), int'(model[i]));
    end
  endtask

  task automatic flag_is(string req, int exp);
    logic [15:0] d;
    rd(4'd0, d);
    chk(req, "flag", int'(d[0]), exp);
  endtask

  task automatic clear_flag();
    logic [15:0] d;
    rd(4'd0, d);
    wr(4'd0, cur & ~11'h005);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [15:0] d, d2;
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd(4'd0, d);
    chk("R1", "control word", int'(d), 0);
    chk("R1", "conv_req", int'(conv_req), 0);
    chk("R1", "irq", int'(irq), 0);
    check_regs("R1");

    // buffering off, channels 0..2, software start
    push(0, 0, "R11"); push(1, 0, "R11"); push(2, 0, "R11");
    cur = cfg(1, 0, 0, 2'b00, 3'b010, 0, 0);
    wr(4'd0, cur | 11'h004);
    wait_idle();
    chk("R5", "conv_req after single sequence", int'(conv_req), 0);
    chk("R2", "irq with flag and enable", int'(irq), 1);
    check_regs("R11");

    // clear rule
    wr(4'd0, cur & ~11'h001);
    flag_is("R3", 1);
    wr(4'd0, cur & ~11'h001);
    flag_is("R3", 0);
    chk("R2", "irq after clear", int'(irq), 0);

    // two-deep buffer, timer trigger; disabled external strobe and busy restarts
    cur = cfg(0, 0, 0, 2'b01, 3'b000, 1, 0);
    wr(4'd0, cur);
    pulse_ext();
    repeat (6) @(negedge clk);
    chk("R4", "conv_req after disabled strobe", int'(conv_req), 0);
    push(0, 2, "R7"); push(0, 2, "R7");
    pulse_tmr();
    repeat (2) @(negedge clk);
    pulse_tmr();
    wr(4'd0, cur | 11'h004);
    wait_idle();
    chk("R4", "conversions after busy starts", popped, 5);
    flag_is("R7", 1);
    chk("R2", "irq with enable off", int'(irq), 0);
    check_regs("R7");
    clear_flag();

    // four-deep buffer, external trigger
    cur = cfg(0, 0, 0, 2'b11, 3'b000, 0, 1);
    wr(4'd0, cur);
    for (int i = 0; i < 4; i++) push(0, 4, "R8");
    pulse_ext();
    wait_idle();
    flag_is("R8", 1);
    check_regs("R8");
    clear_flag();

    // pair buffer
    cur = cfg(0, 0, 0, 2'b10, 3'b000, 0, 0);
    for (int i = 0; i < 2; i++) begin
      push(0, 4, "R9"); push(1, 4, "R9");
    end
    wr(4'd0, cur | 11'h004);
    wait_idle();
    flag_is("R9", 1);
    check_regs("R9");
    clear_flag();

    // four-deep buffer with group channels 4..6
    cur = cfg(0, 0, 0, 2'b11, 3'b110, 0, 0);
    for (int i = 0; i < 4; i++) begin
      push(0, 4, "R10"); push(4, 0, "R10"); push(5, 0, "R10"); push(6, 0, "R10");
    end
    wr(4'd0, cur | 11'h004);
    wait (q.size() == 4);
    flag_is("R12", 0);
    wait_idle();
    flag_is("R12", 1);
    check_regs("R10");
    clear_flag();

    // side-effect-free reads
    rd(4'd8, d);
    rd(4'd8, d2);
    chk("R13", "repeated read of A", int'(d2), int'(d));
    chk("R13", "A against model", int'(d), int'(model[0]));

    // scan mode, channels 0..1
    popped = 0;
    cur = cfg(0, 0, 1, 2'b00, 3'b001, 0, 0);
    for (int i = 0; i < 4; i++) begin
      push(0, 0, "R6"); push(1, 0, "R6");
    end
    wr(4'd0, cur | 11'h004);
    wait (q.size() <= 6);
    repeat (2) @(negedge clk);
    chk("R6", "conv_req after flag in scan", int'(conv_req), 1);
    cur = cfg(0, 0, 0, 2'b00, 3'b001, 0, 0);
    wr(4'd0, cur);
    for (int i = 0; i < 200 && conv_req; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R6", "conv_req after scan off", int'(conv_req), 0);
    chk("R6", "whole passes converted", popped % 2, 0);
    q.delete();
    flag_is("R6", 1);
    check_regs("R6");

    report();
    $finish;
  end

endmodule